// File: doc/BRIEF.md
# I2C Master Receiver with Event Status Codes

This block is the master side of a two-wire serial bus, limited to reading. Software steers it through a set of control strobes. It writes enable, start, stop, acknowledge-enable and flag-clear together in one write. It loads the slave address byte, with the direction bit in bit 0, through a data register. The block forms START, repeated START and STOP conditions. It shifts the address out, clocks data bytes in, and answers each received byte with ACK or NACK.

Each step ends at a stop point. There the block raises an event flag, posts an 8-bit status code and holds the bus still. Software reads the status, picks its next action and releases the block by clearing the flag. Received bytes are read from the data register while the flag is up. Both bus lines are open-drain. Each line has an output enable that pulls it low and an input that reads the wired level. SCL timing comes from a divider parameter: one bit takes four quarter periods of `CLK_DIV` clocks each.

Top module: `i2cRxMaster`

## Requirements
- R1: After reset the event flag is 0, the status code is 0xF8, neither line is pulled low and the stop indicator is 0.
- R2: A write with enable, start and flag-clear all 1, made while the block does not own the bus, waits until both lines read high. It then forms a START and raises the flag with status 0x08.
- R3: From status 0x08 or 0x10, a flag-clear write with start and stop both 0 sends the data register MSB first and samples the ninth slot (low = ACK). If bit 0 is 1 (read) the status is 0x40 on ACK and 0x48 on NACK. If bit 0 is 0 (write) it is 0x18 on ACK and 0x20 on NACK.
- R4: While the flag is set the line drivers do not change. A flag-clear write with start and stop both 0, made in a state that allows no further step (0x48, 0x58, 0x18, 0x20), leaves the flag set, the status unchanged and SCL held low.
- R5: From status 0x40 or 0x50, a flag-clear write with start and stop both 0 clocks in one byte MSB first and places it in the data register. The acknowledge-enable bit of that write decides the ninth slot. A 1 drives ACK and gives status 0x50. A 0 leaves NACK and gives status 0x58.
- R6: A flag-clear write with start 1 and stop 0, made while the bus is owned and the flag is set, forms a repeated START and raises the flag with status 0x10.
- R7: A flag-clear write with stop 1, made while the bus is owned and the flag is set, forms a STOP. The stop indicator is high only while the STOP is forming and then clears by itself. Both lines end released and the flag is not raised.
- R8: If a 1 bit of the address reads back low while SCL is high, the block stops driving both lines. It raises the flag with status 0x38 and no longer owns the bus, so a later START request again waits for a free bus.
- R9: SDA drive changes only while SCL is held low, except during START, repeated START and STOP forming. SCL rising edges within a byte are 4·`CLK_DIV` clocks apart.
- R10: The status code changes only on the cycle the flag rises. An accepted flag-clear write drops the flag on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ctlWrite | input | 1 | Control write strobe |
| wrEnable | input | 1 | Enable bit of the control write |
| wrStart | input | 1 | START / repeated START request bit |
| wrStop | input | 1 | STOP request bit |
| wrAck | input | 1 | Acknowledge-enable for the next received byte |
| wrClear | input | 1 | Write-one-to-clear of the event flag |
| dataWrite | input | 1 | Data register write strobe |
| dataIn | input | 8 | Data register write value (address byte) |
| eventFlag | output | 1 | Event flag; bus is held while it is 1 |
| statusCode | output | 8 | Status of the last stop point |
| dataOut | output | 8 | Data register (received byte) |
| stopBusy | output | 1 | STOP request pending, self-clearing |
| sclOe | output | 1 | Pull SCL low |
| sclIn | input | 1 | SCL wired level |
| sdaOe | output | 1 | Pull SDA low |
| sdaIn | input | 1 | SDA wired level |

## Verification
The bench runs the block against a behavioural slave that decodes the address and serves a computed byte pattern. Read transfers ACK the early bytes and NACK the last. Each received value is checked, which separates correct bit order and capture from an off-by-one shift. A wrong address, a write-direction address and a repeated START each steer the status path to a different code. A second driver pulling SDA low tests two behaviours. Pulled during the address, it must produce arbitration loss with the lines released. Pulled before a START request, it must delay the START until the bus is free. A flag-clear with no legal next step must leave the flag and the bus untouched.

// File: rtl/i2cRxPkg.sv
package i2cRxPkg;

  typedef enum logic [2:0] {
    OP_IDLE,
    OP_FRAME_START,
    OP_FRAME_STOP,
    OP_ADDR,
    OP_RECV
  } opKindT;

  typedef struct packed {
    logic loadShift;
    logic shiftStep;
    logic captureRx;
  } dpStrobeT;

  localparam logic [7:0] CODE_IDLE      = 8'hF8;
  localparam logic [7:0] CODE_START     = 8'h08;
  localparam logic [7:0] CODE_RESTART   = 8'h10;
  localparam logic [7:0] CODE_WADDR_ACK = 8'h18;
  localparam logic [7:0] CODE_WADDR_NAK = 8'h20;
  localparam logic [7:0] CODE_ARB_LOST  = 8'h38;
  localparam logic [7:0] CODE_RADDR_ACK = 8'h40;
  localparam logic [7:0] CODE_RADDR_NAK = 8'h48;
  localparam logic [7:0] CODE_DATA_ACK  = 8'h50;
  localparam logic [7:0] CODE_DATA_NAK  = 8'h58;

endpackage

// File: rtl/i2cRxDatapath.sv
module i2cRxDatapath
  import i2cRxPkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobeT          strobe,
  input  logic              sdaSample,
  input  logic              dataWrite,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dataOut,
  output logic              txBit
);

  logic [DATA_W-1:0] dataReg;
  logic [DATA_W-1:0] shiftReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataReg  <= '0;
      shiftReg <= '0;
    end else begin
      if (strobe.captureRx) begin
        dataReg <= shiftReg;
      end else if (dataWrite) begin
        dataReg <= dataIn;
      end
      if (strobe.loadShift) begin
        shiftReg <= dataReg;
      end else if (strobe.shiftStep) begin
        shiftReg <= {shiftReg[DATA_W-2:0], sdaSample};
      end
    end
  end

  assign dataOut = dataReg;
  assign txBit   = shiftReg[DATA_W-1];

endmodule

// File: rtl/i2cRxControl.sv
module i2cRxControl
  import i2cRxPkg::*;
#(
  parameter int CLK_DIV = 4,
  parameter int DATA_W  = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       ctlWrite,
  input  logic       wrEnable,
  input  logic       wrStart,
  input  logic       wrStop,
  input  logic       wrAck,
  input  logic       wrClear,
  input  logic       txBit,
  input  logic       addrDir,
  input  logic       sclIn,
  input  logic       sdaIn,
  output dpStrobeT   strobe,
  output logic       eventFlag,
  output logic [7:0] statusCode,
  output logic       stopBusy,
  output logic       framingOp,
  output logic       sclOe,
  output logic       sdaOe
);

  localparam int DIV_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam int BIT_W = $clog2(DATA_W + 1);
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLK_DIV - 1);
  localparam logic [BIT_W-1:0] ACK_SLOT = BIT_W'(DATA_W);

  opKindT           opKind;
  logic [DIV_W-1:0] divCnt;
  logic [1:0]       quarter;
  logic [BIT_W-1:0] bitCnt;
  logic             flag, busOwned, pendStart, ackEn, dirRead, ackSeen;
  logic             sclLow, sdaLow;
  logic [7:0]       status;

  logic tick, go, held, canAddr, canRecv, dataBit;
  logic cmdFresh, cmdStop, cmdRestart, cmdAddr, cmdRecv, launchStart;

  always_comb begin
    tick        = (opKind != OP_IDLE) && (divCnt == DIV_LAST);
    go          = ctlWrite && wrEnable && wrClear && (opKind == OP_IDLE);
    held        = go && busOwned && flag;
    canAddr     = (status == CODE_START) || (status == CODE_RESTART);
    canRecv     = (status == CODE_RADDR_ACK) || (status == CODE_DATA_ACK);
    cmdFresh    = go && !busOwned && wrStart;
    cmdStop     = held && wrStop;
    cmdRestart  = held && wrStart && !wrStop;
    cmdAddr     = held && !wrStart && !wrStop && canAddr;
    cmdRecv     = held && !wrStart && !wrStop && canRecv;
    launchStart = pendStart && (opKind == OP_IDLE) && sclIn && sdaIn;
    dataBit     = bitCnt < ACK_SLOT;

    strobe           = '0;
    strobe.loadShift = cmdAddr;
    strobe.shiftStep = ((opKind == OP_ADDR) || (opKind == OP_RECV)) &&
                       tick && (quarter == 2'd2) && dataBit;
    strobe.captureRx = (opKind == OP_RECV) && tick && (quarter == 2'd3) &&
                       (bitCnt == ACK_SLOT);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opKind    <= OP_IDLE;
      divCnt    <= '0;
      quarter   <= 2'd0;
      bitCnt    <= '0;
      flag      <= 1'b0;
      status    <= CODE_IDLE;
      busOwned  <= 1'b0;
      pendStart <= 1'b0;
      ackEn     <= 1'b0;
      dirRead   <= 1'b0;
      ackSeen   <= 1'b0;
      sclLow    <= 1'b0;
      sdaLow    <= 1'b0;
    end else if (opKind == OP_IDLE) begin
      divCnt  <= '0;
      quarter <= 2'd0;
      bitCnt  <= '0;
      if (go) ackEn <= wrAck;
      if (cmdFresh) begin
        pendStart <= 1'b1;
        flag      <= 1'b0;
      end
      if (cmdStop) begin
        opKind <= OP_FRAME_STOP;
        flag   <= 1'b0;
      end
      if (cmdRestart) begin
        opKind <= OP_FRAME_START;
        flag   <= 1'b0;
      end
      if (cmdAddr) begin
        opKind  <= OP_ADDR;
        flag    <= 1'b0;
        dirRead <= addrDir;
      end
      if (cmdRecv) begin
        opKind <= OP_RECV;
        flag   <= 1'b0;
      end
      if (launchStart) begin
        opKind    <= OP_FRAME_START;
        pendStart <= 1'b0;
      end
    end else begin
      divCnt <= tick ? '0 : divCnt + 1'b1;
      if (tick) begin
        quarter <= quarter + 2'd1;
        case (opKind)
          OP_FRAME_START: begin
            case (quarter)
              2'd0: sdaLow <= 1'b0;
              2'd1: sclLow <= 1'b0;
              2'd2: sdaLow <= 1'b1;
              default: begin
                sclLow   <= 1'b1;
                opKind   <= OP_IDLE;
                flag     <= 1'b1;
                status   <= busOwned ? CODE_RESTART : CODE_START;
                busOwned <= 1'b1;
              end
            endcase
          end
          OP_FRAME_STOP: begin
            case (quarter)
              2'd0: sdaLow <= 1'b1;
              2'd1: sclLow <= 1'b0;
              2'd2: sdaLow <= 1'b0;
              default: begin
                opKind   <= OP_IDLE;
                busOwned <= 1'b0;
              end
            endcase
          end
          OP_ADDR, OP_RECV: begin
            case (quarter)
              2'd0: begin
                if (opKind == OP_ADDR) sdaLow <= dataBit ? !txBit : 1'b0;
                else                   sdaLow <= dataBit ? 1'b0 : ackEn;
              end
              2'd1: sclLow <= 1'b0;
              2'd2: begin
                if (!dataBit) ackSeen <= !sdaIn;
                if ((opKind == OP_ADDR) && dataBit && !sdaLow && !sdaIn) begin
                  opKind   <= OP_IDLE;
                  sdaLow   <= 1'b0;
                  sclLow   <= 1'b0;
                  busOwned <= 1'b0;
                  flag     <= 1'b1;
                  status   <= CODE_ARB_LOST;
                end
              end
              default: begin
                sclLow <= 1'b1;
                if (!dataBit) begin
                  opKind <= OP_IDLE;
                  flag   <= 1'b1;
                  bitCnt <= '0;
                  if (opKind == OP_RECV)
                    status <= ackEn ? CODE_DATA_ACK : CODE_DATA_NAK;
                  else if (dirRead)
                    status <= ackSeen ? CODE_RADDR_ACK : CODE_RADDR_NAK;
                  else
                    status <= ackSeen ? CODE_WADDR_ACK : CODE_WADDR_NAK;
                end else begin
                  bitCnt <= bitCnt + 1'b1;
                end
              end
            endcase
          end
          default: opKind <= OP_IDLE;
        endcase
      end
    end
  end

  assign eventFlag  = flag;
  assign statusCode = status;
  assign stopBusy   = (opKind == OP_FRAME_STOP);
  assign framingOp  = (opKind == OP_FRAME_START) || (opKind == OP_FRAME_STOP);
  assign sclOe      = sclLow;
  assign sdaOe      = sdaLow;

endmodule

// File: rtl/i2cRxMaster.sv
module i2cRxMaster
  import i2cRxPkg::*;
#(
  parameter int CLK_DIV = 4,
  parameter int DATA_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctlWrite,
  input  logic              wrEnable,
  input  logic              wrStart,
  input  logic              wrStop,
  input  logic              wrAck,
  input  logic              wrClear,
  input  logic              dataWrite,
  input  logic [DATA_W-1:0] dataIn,
  output logic              eventFlag,
  output logic [7:0]        statusCode,
  output logic [DATA_W-1:0] dataOut,
  output logic              stopBusy,
  output logic              sclOe,
  input  logic              sclIn,
  output logic              sdaOe,
  input  logic              sdaIn
);

  dpStrobeT dpStrobe;
  logic     txBit;
  logic     framingOp;

  i2cRxControl #(.CLK_DIV(CLK_DIV), .DATA_W(DATA_W)) u_control (
    .clk(clk), .rstN(rstN),
    .ctlWrite(ctlWrite), .wrEnable(wrEnable), .wrStart(wrStart),
    .wrStop(wrStop), .wrAck(wrAck), .wrClear(wrClear),
    .txBit(txBit), .addrDir(dataOut[0]),
    .sclIn(sclIn), .sdaIn(sdaIn),
    .strobe(dpStrobe), .eventFlag(eventFlag), .statusCode(statusCode),
    .stopBusy(stopBusy), .framingOp(framingOp),
    .sclOe(sclOe), .sdaOe(sdaOe)
  );

  i2cRxDatapath #(.DATA_W(DATA_W)) u_datapath (
    .clk(clk), .rstN(rstN),
    .strobe(dpStrobe), .sdaSample(sdaIn),
    .dataWrite(dataWrite), .dataIn(dataIn),
    .dataOut(dataOut), .txBit(txBit)
  );

endmodule

// File: rtl/i2cRxMasterChecker.sv
module i2cRxMasterChecker (
  input logic       clk,
  input logic       rstN,
  input logic       eventFlag,
  input logic [7:0] statusCode,
  input logic       stopBusy,
  input logic       framingOp,
  input logic       sclOe,
  input logic       sdaOe
);

  // R4
  bus_frozen_chk: assert property (@(posedge clk) disable iff (!rstN)
    (eventFlag && $past(eventFlag)) |-> ($stable(sclOe) && $stable(sdaOe)));

  // R10
  status_on_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(statusCode) |-> $rose(eventFlag));

  // R7
  stop_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(stopBusy) |-> (!eventFlag && !sclOe && !sdaOe));

  // R9
  sda_while_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(sdaOe) && !framingOp && !$past(framingOp)) |-> (sclOe && $past(sclOe)));

  // R3
  legal_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    eventFlag |-> (statusCode inside {8'h08, 8'h10, 8'h18, 8'h20, 8'h38,
                                      8'h40, 8'h48, 8'h50, 8'h58}));

endmodule

bind i2cRxMaster i2cRxMasterChecker u_checker (
  .clk(clk), .rstN(rstN), .eventFlag(eventFlag), .statusCode(statusCode),
  .stopBusy(stopBusy), .framingOp(framingOp), .sclOe(sclOe), .sdaOe(sdaOe)
);

// File: tb/test_i2cRxMaster.sv
module test_i2cRxMaster;

  localparam int CLK_PERIOD = 10;
  localparam int BENCH_DIV  = 4;
  localparam logic [6:0] SLV_ADDR = 7'h52;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ctlWrite = 1'b0, wrEnable = 1'b0, wrStart = 1'b0, wrStop = 1'b0;
  logic wrAck = 1'b0, wrClear = 1'b0, dataWrite = 1'b0;
  logic [7:0] dataIn = 8'h00;
  logic eventFlag, stopBusy, sclOe, sdaOe;
  logic [7:0] statusCode, dataOut;
  logic slvSdaLow = 1'b0, extSdaLow = 1'b0;
  wire  sclLine = !sclOe;
  wire  sdaLine = !(sdaOe || slvSdaLow || extSdaLow);

  int checks = 0, failures = 0, pushCount = 0, popCount = 0;
  int lastPeriod = 0, sclCnt = 0;
  bit finished = 1'b0;

  logic [7:0] codeQ[$];
  logic [7:0] dataQ[$];
  bit         chkQ[$];
  string      reqQ[$];

  always #(CLK_PERIOD / 2) clk = ~clk;

  i2cRxMaster #(.CLK_DIV(BENCH_DIV)) i_i2cRxMaster (
    .clk(clk), .rstN(rstN), .ctlWrite(ctlWrite), .wrEnable(wrEnable),
    .wrStart(wrStart), .wrStop(wrStop), .wrAck(wrAck), .wrClear(wrClear),
    .dataWrite(dataWrite), .dataIn(dataIn), .eventFlag(eventFlag),
    .statusCode(statusCode), .dataOut(dataOut), .stopBusy(stopBusy),
    .sclOe(sclOe), .sclIn(sclLine), .sdaOe(sdaOe), .sdaIn(sdaLine)
  );

  function automatic logic [7:0] patByte(input int idx);
    return 8'hC3 ^ 8'(idx * 41);
  endfunction

  task automatic checkVal(input bit ok, input string req, input string what,
                          input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // slave model and SCL period measurement, all sampled away from the active edge
  typedef enum int {S_IDLE, S_ADDR, S_ACKA, S_TX, S_RXACK} slvStateT;
  slvStateT sState = S_IDLE;
  logic prevScl = 1'b1, prevSda = 1'b1, readMode = 1'b0, masterAck = 1'b0;
  logic [7:0] shiftIn = 8'h00, txByte = 8'h00;
  int bitCnt = 0, byteIdx = 0;

  always @(negedge clk) begin
    sclCnt++;
    if (prevScl && sclLine && prevSda && !sdaLine) begin
      sState = S_ADDR; bitCnt = 0; slvSdaLow = 1'b0;
    end else if (prevScl && sclLine && !prevSda && sdaLine) begin
      sState = S_IDLE; slvSdaLow = 1'b0;
    end else if (!prevScl && sclLine) begin
      lastPeriod = sclCnt;
      sclCnt = 0;
      if (sState == S_ADDR) begin
        shiftIn = {shiftIn[6:0], sdaLine};
        bitCnt++;
      end else if (sState == S_RXACK) begin
        masterAck = !sdaLine;
      end
    end else if (prevScl && !sclLine) begin
      case (sState)
        S_ADDR: if (bitCnt == 8) begin
          if (shiftIn[7:1] == SLV_ADDR) begin
            slvSdaLow = 1'b1; readMode = shiftIn[0]; byteIdx = 0; sState = S_ACKA;
          end else begin
            sState = S_IDLE;
          end
        end
        S_ACKA: if (readMode) begin
          txByte = patByte(byteIdx); slvSdaLow = !txByte[7]; bitCnt = 1; sState = S_TX;
        end else begin
          slvSdaLow = 1'b0; sState = S_IDLE;
        end
        S_TX: if (bitCnt == 8) begin
          slvSdaLow = 1'b0; sState = S_RXACK;
        end else begin
          slvSdaLow = !txByte[7 - bitCnt]; bitCnt++;
        end
        S_RXACK: if (masterAck) begin
          byteIdx++; txByte = patByte(byteIdx);
          slvSdaLow = !txByte[7]; bitCnt = 1; sState = S_TX;
        end else begin
          slvSdaLow = 1'b0; sState = S_IDLE;
        end
        default: ;
      endcase
    end
    prevScl = sclLine;
    prevSda = sdaLine;
  end

  // monitor: pops one expected stop point per rising event flag
  logic prevFlag = 1'b0;
  always @(negedge clk) begin
    if (rstN && eventFlag && !prevFlag) begin
      if (codeQ.size() == 0) begin
        checkVal(1'b0, "R7", "unexpected flag", 16'(statusCode), 16'h0);
      end else begin
        logic [7:0] eCode, eData;
        bit eChk;
        string eReq;
        eCode = codeQ.pop_front(); eData = dataQ.pop_front();
        eChk = chkQ.pop_front(); eReq = reqQ.pop_front();
        checkVal(statusCode == eCode, eReq, "status", 16'(statusCode), 16'(eCode));
        if (eChk)
          checkVal(dataOut == eData, eReq, "rx data", 16'(dataOut), 16'(eData));
        popCount++;
      end
    end
    prevFlag = eventFlag;
  end

  task automatic pushExp(input logic [7:0] code, input bit chk,
                         input logic [7:0] data, input string req);
    codeQ.push_back(code); dataQ.push_back(data);
    chkQ.push_back(chk); reqQ.push_back(req);
    pushCount++;
  endtask

  task automatic ctl(input logic st, input logic sp, input logic ak);
    @(negedge clk);
    ctlWrite = 1'b1; wrEnable = 1'b1; wrClear = 1'b1;
    wrStart = st; wrStop = sp; wrAck = ak;
    @(negedge clk);
    ctlWrite = 1'b0; wrEnable = 1'b0; wrClear = 1'b0;
    wrStart = 1'b0; wrStop = 1'b0; wrAck = 1'b0;
  endtask

  task automatic loadData(input logic [7:0] b);
    @(negedge clk);
    dataWrite = 1'b1; dataIn = b;
    @(negedge clk);
    dataWrite = 1'b0;
  endtask

  task automatic step(input logic st, input logic sp, input logic ak,
                      input logic [7:0] code, input bit chk,
                      input logic [7:0] data, input string req);
    pushExp(code, chk, data, req);
    ctl(st, sp, ak);
    // R10: accepted flag-clear drops the flag on the next edge
    checkVal(eventFlag == 1'b0, "R10", "flag after clear", 16'(eventFlag), 16'h0);
    wait (popCount == pushCount);
  endtask

  task automatic stopSeq();
    ctl(1'b0, 1'b1, 1'b0);
    checkVal(stopBusy == 1'b1, "R7", "stop pending", 16'(stopBusy), 16'h1);
    wait (!stopBusy);
    repeat (30) @(negedge clk);
    checkVal(eventFlag == 1'b0, "R7", "flag after stop", 16'(eventFlag), 16'h0);
    checkVal({sclOe, sdaOe} == 2'b00, "R7", "lines after stop", 16'({sclOe, sdaOe}), 16'h0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1
    checkVal(eventFlag == 1'b0, "R1", "reset flag", 16'(eventFlag), 16'h0);
    checkVal(statusCode == 8'hF8, "R1", "reset status", 16'(statusCode), 16'hF8);
    checkVal({sclOe, sdaOe, stopBusy} == 3'b000, "R1", "reset lines",
             16'({sclOe, sdaOe, stopBusy}), 16'h0);

    // read transfer: ACK, ACK, NACK
    step(1'b1, 1'b0, 1'b1, 8'h08, 1'b0, 8'h00, "R2");
    loadData({SLV_ADDR, 1'b1});
    step(1'b0, 1'b0, 1'b1, 8'h40, 1'b0, 8'h00, "R3");
    step(1'b0, 1'b0, 1'b1, 8'h50, 1'b1, patByte(0), "R5");
    step(1'b0, 1'b0, 1'b1, 8'h50, 1'b1, patByte(1), "R5");
    step(1'b0, 1'b0, 1'b0, 8'h58, 1'b1, patByte(2), "R5");
    checkVal(lastPeriod == 4 * BENCH_DIV, "R9", "scl period",
             16'(lastPeriod), 16'(4 * BENCH_DIV));

    // R4: clear with no legal step is ignored
    ctl(1'b0, 1'b0, 1'b1);
    repeat (40) @(negedge clk);
    checkVal(eventFlag == 1'b1, "R4", "flag kept", 16'(eventFlag), 16'h1);
    checkVal(statusCode == 8'h58, "R4", "status kept", 16'(statusCode), 16'h58);
    checkVal(sclOe == 1'b1, "R4", "scl held", 16'(sclOe), 16'h1);
    stopSeq();

    // wrong address, repeated START, short read
    step(1'b1, 1'b0, 1'b1, 8'h08, 1'b0, 8'h00, "R2");
    loadData(8'h67);
    step(1'b0, 1'b0, 1'b1, 8'h48, 1'b0, 8'h00, "R3");
    step(1'b1, 1'b0, 1'b1, 8'h10, 1'b0, 8'h00, "R6");
    loadData({SLV_ADDR, 1'b1});
    step(1'b0, 1'b0, 1'b0, 8'h40, 1'b0, 8'h00, "R3");
    step(1'b0, 1'b0, 1'b0, 8'h58, 1'b1, patByte(0), "R5");
    stopSeq();

    // write-direction addresses
    step(1'b1, 1'b0, 1'b1, 8'h08, 1'b0, 8'h00, "R2");
    loadData({SLV_ADDR, 1'b0});
    step(1'b0, 1'b0, 1'b1, 8'h18, 1'b0, 8'h00, "R3");
    step(1'b1, 1'b0, 1'b1, 8'h10, 1'b0, 8'h00, "R6");
    loadData(8'h66);
    step(1'b0, 1'b0, 1'b1, 8'h20, 1'b0, 8'h00, "R3");
    stopSeq();

    // R8: arbitration loss during the address
    step(1'b1, 1'b0, 1'b1, 8'h08, 1'b0, 8'h00, "R2");
    @(negedge clk); extSdaLow = 1'b1;
    loadData({SLV_ADDR, 1'b1});
    step(1'b0, 1'b0, 1'b1, 8'h38, 1'b0, 8'h00, "R8");
    checkVal({sclOe, sdaOe} == 2'b00, "R8", "lines after loss", 16'({sclOe, sdaOe}), 16'h0);
    @(negedge clk); extSdaLow = 1'b0;
    repeat (10) @(negedge clk);

    // R2: START waits for a free bus
    extSdaLow = 1'b1;
    pushExp(8'h08, 1'b0, 8'h00, "R2");
    ctl(1'b1, 1'b0, 1'b1);
    checkVal(eventFlag == 1'b0, "R10", "flag after clear", 16'(eventFlag), 16'h0);
    repeat (60) @(negedge clk);
    checkVal(eventFlag == 1'b0, "R2", "no start on busy bus", 16'(eventFlag), 16'h0);
    checkVal({sclOe, sdaOe} == 2'b00, "R2", "idle while busy", 16'({sclOe, sdaOe}), 16'h0);
    extSdaLow = 1'b0;
    wait (popCount == pushCount);
    loadData({SLV_ADDR, 1'b1});
    step(1'b0, 1'b0, 1'b0, 8'h40, 1'b0, 8'h00, "R3");
    step(1'b0, 1'b0, 1'b0, 8'h58, 1'b1, patByte(0), "R5");
    stopSeq();

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule